// File: doc/BRIEF.md
# Three-Lane Block-Parallel Three-Tap FIR Filter

This block computes a three-tap finite impulse response y(n) = a0·x(n) + a1·x(n−1) + a2·x(n−2) at three samples per clock. Every cycle in which the input strobe is high, it takes one block of three consecutive stream samples on three lanes. Lane 0 carries the oldest sample of the block and lane 2 the newest. In return it delivers the three matching filter outputs on three output lanes.

The block does not shift one sample per clock through a single delay chain. It evaluates one closed formula per lane. Lane 0 needs the two newest samples of the previous valid block, and lane 1 needs the newest one. These are held in a two-entry history that advances only on valid blocks, so idle cycles between blocks do not break the stream. Coefficients are static inputs. Outputs are full-precision signed sums, registered once. An optional second register stage can be enabled with the `EXTRA_REG` parameter.

Top module: `fir3p_top`

## Requirements
- R1: Lane 0 output equals a0·x0 + a1·p2 + a2·p1. Here x0, x1 and x2 are the lane 0, lane 1 and lane 2 inputs of the current valid block, p1 is the lane 1 input of the previous valid block and p2 is the lane 2 input of the previous valid block.
- R2: Lane 1 output equals a0·x1 + a1·x0 + a2·p2.
- R3: Lane 2 output equals a0·x2 + a1·x1 + a2·x0, which uses only the current block.
- R4: The history (p1, p2) advances only on cycles with `in_valid` high. Data on the input lanes during cycles with `in_valid` low has no effect on any later output.
- R5: After reset, `out_valid` is 0, all output lanes are 0, and the history is 0. The first valid block after reset therefore treats the earlier samples as zero.
- R6: With the default `EXTRA_REG` = 0, `out_valid` equals `in_valid` delayed by exactly one clock. Each valid block yields exactly one valid output block.
- R7: Outputs are exact signed 34-bit sums with no wrap. With all coefficients and samples at −32768, every lane of a block whose history is also at −32768 reads 3221225472.
- R8: While `out_valid` is 0, the output lanes keep the value of the last valid output block.
- R9: A reset asserted in the middle of a stream clears the history, so the next block filters as if it were the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block strobe |
| in_x0 | input | 16 | Oldest sample of the block, signed |
| in_x1 | input | 16 | Middle sample of the block, signed |
| in_x2 | input | 16 | Newest sample of the block, signed |
| coef_a0 | input | 16 | Coefficient for x(n), signed, static |
| coef_a1 | input | 16 | Coefficient for x(n−1), signed, static |
| coef_a2 | input | 16 | Coefficient for x(n−2), signed, static |
| out_valid | output | 1 | Output block strobe |
| out_y0 | output | 34 | Output for the oldest sample, signed |
| out_y1 | output | 34 | Output for the middle sample, signed |
| out_y2 | output | 34 | Output for the newest sample, signed |

## Verification
The hardest case to reach is lane 0 and lane 1 reading history that was written several cycles earlier, across a gap in which the input lanes carried unrelated data. The stimulus inserts random runs of idle cycles between blocks and drives random values on the lanes during those cycles. Every lane is compared against a serial one-sample-at-a-time model that never sees the idle data. Directed blocks at the most negative values and a reset inserted mid-stream cover the width limit and the cleared history.

// File: rtl/fir3p_pkg.sv
package fir3p_pkg;
    localparam int DW    = 16;
    localparam int CW    = 16;
    localparam int LANES = 3;
    localparam int TAPS  = 3;
    localparam int OW    = DW + CW + $clog2(TAPS) + 1;

    typedef logic signed [DW-1:0] samp_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [OW-1:0] acc_t;

    typedef struct packed {
        samp_t l2;
        samp_t l1;
        samp_t l0;
    } blk_t;

    typedef struct packed {
        acc_t l2;
        acc_t l1;
        acc_t l0;
    } yblk_t;

    typedef struct packed {
        coef_t c2;
        coef_t c1;
        coef_t c0;
    } coefs_t;

    typedef struct packed {
        samp_t older;
        samp_t newer;
    } hist_t;

    function automatic acc_t mac3(input coef_t c0, input coef_t c1, input coef_t c2,
                                  input samp_t s0, input samp_t s1, input samp_t s2);
        acc_t r;
        r = acc_t'(c0) * acc_t'(s0) + acc_t'(c1) * acc_t'(s1) + acc_t'(c2) * acc_t'(s2);
        return r;
    endfunction
endpackage

// File: rtl/fir3p_hist.sv
module fir3p_hist
    import fir3p_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  blk_t  blk,
    output hist_t hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (adv) begin
            hist.older <= blk.l1;
            hist.newer <= blk.l2;
        end
    end
endmodule

// File: rtl/fir3p_lane_mac.sv
module fir3p_lane_mac
    import fir3p_pkg::*;
(
    input  coefs_t coefs,
    input  hist_t  hist,
    input  blk_t   blk,
    output yblk_t  y
);
    samp_t ext [LANES+TAPS-1];
    acc_t  lane_y [LANES];

    always_comb begin
        ext[0] = hist.older;
        ext[1] = hist.newer;
        ext[2] = blk.l0;
        ext[3] = blk.l1;
        ext[4] = blk.l2;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_y[j] = mac3(coefs.c0, coefs.c1, coefs.c2,
                                ext[j+TAPS-1], ext[j+TAPS-2], ext[j+TAPS-3]);
    end

    assign y.l0 = lane_y[0];
    assign y.l1 = lane_y[1];
    assign y.l2 = lane_y[2];
endmodule

// File: rtl/fir3p_out_reg.sv
module fir3p_out_reg
    import fir3p_pkg::*;
#(
    parameter int EXTRA_REG = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  vld_in,
    input  yblk_t y_in,
    output logic  vld_out,
    output yblk_t y_out
);
    localparam int STAGES = 1 + ((EXTRA_REG != 0) ? 1 : 0);

    logic  vld_s [STAGES+1];
    yblk_t y_s   [STAGES+1];

    assign vld_s[0] = vld_in;
    assign y_s[0]   = y_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_s[s+1] <= 1'b0;
                y_s[s+1]   <= '0;
            end else begin
                vld_s[s+1] <= vld_s[s];
                if (vld_s[s]) y_s[s+1] <= y_s[s];
            end
        end
    end

    assign vld_out = vld_s[STAGES];
    assign y_out   = y_s[STAGES];
endmodule

// File: rtl/fir3p_top.sv
module fir3p_top
    import fir3p_pkg::*;
#(
    parameter int EXTRA_REG = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic signed [15:0] in_x0,
    input  logic signed [15:0] in_x1,
    input  logic signed [15:0] in_x2,
    input  logic signed [15:0] coef_a0,
    input  logic signed [15:0] coef_a1,
    input  logic signed [15:0] coef_a2,
    output logic             out_valid,
    output logic signed [33:0] out_y0,
    output logic signed [33:0] out_y1,
    output logic signed [33:0] out_y2
);
    blk_t   blk;
    coefs_t coefs;
    hist_t  hist;
    yblk_t  y_comb;
    yblk_t  y_reg;

    assign blk   = '{l2: in_x2, l1: in_x1, l0: in_x0};
    assign coefs = '{c2: coef_a2, c1: coef_a1, c0: coef_a0};

    fir3p_hist u_hist (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .blk  (blk),
        .hist (hist)
    );

    fir3p_lane_mac u_mac (
        .coefs (coefs),
        .hist  (hist),
        .blk   (blk),
        .y     (y_comb)
    );

    fir3p_out_reg #(.EXTRA_REG(EXTRA_REG)) u_out (
        .clk     (clk),
        .rst     (rst),
        .vld_in  (in_valid),
        .y_in    (y_comb),
        .vld_out (out_valid),
        .y_out   (y_reg)
    );

    assign out_y0 = y_reg.l0;
    assign out_y1 = y_reg.l1;
    assign out_y2 = y_reg.l2;
endmodule

// File: rtl/fir3p_chk.sv
module fir3p_chk #(
    parameter int EXTRA_REG = 0
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic signed [15:0] in_x0,
    input logic signed [15:0] in_x1,
    input logic signed [15:0] in_x2,
    input logic signed [15:0] coef_a0,
    input logic signed [15:0] coef_a1,
    input logic signed [15:0] coef_a2,
    input logic               out_valid,
    input logic signed [33:0] out_y0,
    input logic signed [33:0] out_y1,
    input logic signed [33:0] out_y2
);
    localparam longint LIM = 64'sd3 * 64'sd1073741824;

    logic signed [15:0] sh_p1, sh_p2;
    logic signed [33:0] y0_now, y2_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_p1 <= '0;
            sh_p2 <= '0;
        end else if (in_valid) begin
            sh_p1 <= in_x1;
            sh_p2 <= in_x2;
        end
    end

    assign y0_now = 34'(coef_a0 * in_x0) + 34'(coef_a1 * sh_p2) + 34'(coef_a2 * sh_p1);
    assign y2_now = 34'(coef_a0 * in_x2) + 34'(coef_a1 * in_x1) + 34'(coef_a2 * in_x0);

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_y0 == 0 && out_y1 == 0 && out_y2 == 0));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (longint'(out_y0) <= LIM && longint'(out_y0) >= -LIM &&
         longint'(out_y1) <= LIM && longint'(out_y1) >= -LIM &&
         longint'(out_y2) <= LIM && longint'(out_y2) >= -LIM));

    if (EXTRA_REG == 0) begin : g_lat1
        // R6
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R6
        idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        // R3
        lane2_sum_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_y2 == $past(y2_now)));
        // R1
        lane0_hist_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_y0 == $past(y0_now)));
    end
endmodule

bind fir3p_top fir3p_chk #(.EXTRA_REG(EXTRA_REG)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2),
    .coef_a0(coef_a0), .coef_a1(coef_a1), .coef_a2(coef_a2),
    .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
);

// File: tb/sim_fir3p_top.sv
`timescale 1ns/1ps
module sim_fir3p_top;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_x0 = '0, in_x1 = '0, in_x2 = '0;
    logic signed [15:0] coef_a0 = '0, coef_a1 = '0, coef_a2 = '0;
    logic               out_valid;
    logic signed [33:0] out_y0, out_y1, out_y2;

    int     n_checks = 0;
    int     n_fail   = 0;
    bit     done     = 1'b0;
    longint q_y[$];
    string  q_tag[$];
    longint g_h1 = 0, g_h2 = 0;
    logic   vld_d = 1'b0;
    longint held0 = 0, held1 = 0, held2 = 0;

    always #2.5 clk = ~clk;

    fir3p_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_x0(in_x0), .in_x1(in_x1), .in_x2(in_x2),
        .coef_a0(coef_a0), .coef_a1(coef_a1), .coef_a2(coef_a2),
        .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // serial golden model, one sample at a time
    function automatic longint serial_step(input longint x);
        longint y;
        y = longint'(coef_a0) * x + longint'(coef_a1) * g_h1 + longint'(coef_a2) * g_h2;
        g_h2 = g_h1;
        g_h1 = x;
        return y;
    endfunction

    task automatic drive_block(input logic signed [15:0] a, input logic signed [15:0] b,
                               input logic signed [15:0] c, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_x0 = a; in_x1 = b; in_x2 = c;
        q_y.push_back(serial_step(longint'(a))); q_tag.push_back({"R1 ", tag});
        q_y.push_back(serial_step(longint'(b))); q_tag.push_back({"R2 ", tag});
        q_y.push_back(serial_step(longint'(c))); q_tag.push_back({"R3 ", tag});
    endtask

    task automatic drive_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_x0 = 16'($urandom); in_x1 = 16'($urandom); in_x2 = 16'($urandom);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; in_valid = 1'b0;
        g_h1 = 0; g_h2 = 0;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    always @(posedge clk) vld_d <= rst ? 1'b0 : in_valid;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R6 out_valid one cycle after in_valid", longint'(out_valid), longint'(vld_d));
            if (out_valid) begin
                if (q_y.size() < 3) begin
                    check("R6 unexpected output block", 0, 1);
                end else begin
                    string t0, t1, t2;
                    longint e0, e1, e2;
                    e0 = q_y.pop_front(); t0 = q_tag.pop_front();
                    e1 = q_y.pop_front(); t1 = q_tag.pop_front();
                    e2 = q_y.pop_front(); t2 = q_tag.pop_front();
                    check(t0, longint'(out_y0), e0);
                    check(t1, longint'(out_y1), e1);
                    check(t2, longint'(out_y2), e2);
                end
                held0 = longint'(out_y0); held1 = longint'(out_y1); held2 = longint'(out_y2);
            end else begin
                check("R8 lane0 held", longint'(out_y0), held0);
                check("R8 lane1 held", longint'(out_y1), held1);
                check("R8 lane2 held", longint'(out_y2), held2);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        coef_a0 = 16'sd3; coef_a1 = -16'sd5; coef_a2 = 16'sd7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state
        check("R5 out_valid after reset", longint'(out_valid), 0);
        check("R5 out_y0 after reset", longint'(out_y0), 0);
        check("R5 out_y1 after reset", longint'(out_y1), 0);
        check("R5 out_y2 after reset", longint'(out_y2), 0);
        rst = 1'b0;
        drive_idle(2);

        // R5: first block sees zero history; then back-to-back stream
        drive_block(16'sd10, 16'sd20, 16'sd30, "R5 first");
        drive_block(16'sd1, -16'sd2, 16'sd4, "back-to-back");
        drive_block(16'sd100, 16'sd0, -16'sd100, "back-to-back");
        drive_idle(3);

        // R4: random stream with random gaps and junk data on idle cycles
        for (int r = 0; r < 3; r++) begin
            drive_idle(2);
            coef_a0 = 16'($urandom); coef_a1 = 16'($urandom); coef_a2 = 16'($urandom);
            for (int i = 0; i < 150; i++) begin
                drive_block(16'($urandom), 16'($urandom), 16'($urandom), "R4 stream");
                if (($urandom % 3) == 0) drive_idle(1 + int'($urandom % 4));
            end
            drive_idle(2);
        end

        // R7: extreme values, full precision
        coef_a0 = -16'sd32768; coef_a1 = -16'sd32768; coef_a2 = -16'sd32768;
        drive_block(-16'sd32768, -16'sd32768, -16'sd32768, "R7 extreme fill");
        drive_block(-16'sd32768, -16'sd32768, -16'sd32768, "R7 extreme");
        drive_idle(3);
        check("R7 lane2 extreme value", held2, 64'sd3221225472);
        check("R7 lane0 extreme value", held0, 64'sd3221225472);

        // R9: reset in mid-stream clears history
        coef_a0 = 16'sd2; coef_a1 = 16'sd3; coef_a2 = 16'sd4;
        drive_block(16'sd50, 16'sd60, 16'sd70, "pre-reset");
        drive_idle(2);
        do_reset();
        held0 = 0; held1 = 0; held2 = 0;
        drive_block(16'sd1, 16'sd1, 16'sd1, "R9 after reset");
        drive_idle(3);
        check("R9 lane0 after mid reset", held0, 64'sd2);
        check("R9 lane1 after mid reset", held1, 64'sd5);

        check("R6 every block produced", longint'(q_y.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule